// File: doc/BRIEF.md
# Circular Queue with Pairwise-Sum Processing

This block is a first-in, first-out store of `K` small data words (4 bits by default) arranged as a ring over a register file. The register file has two read ports and one write port. A read index marks the oldest valid word and a write index marks the next free slot. Both indices wrap modulo `K`. An occupancy counter that runs from 0 to `K` tells a full ring from an empty one.

Besides push and pop, the block accepts a combine command. In a single clock, the combine command takes the two oldest words through the two read ports, drops both from the front, and appends their 4-bit sum at the back. Combining the values 1, 2, 3, 4 and 5 over and over therefore leaves one word, 15. The oldest word is always visible on an output. Full and empty flags are also driven. An illegal push or pop produces a one-cycle error pulse and does not change the queue.

Top module: `circq_sum`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `empty_o`=1, `full_o`=0, `err_o`=0 and `head_o`=0.
- R2: A push writes `din_i` at the back. A pop removes the front. Words leave in the order they arrived, and the indices wrap modulo `K` without losing order.
- R3: `empty_o` is 1 exactly when no word is held. `full_o` is 1 exactly when `K` words are held. The occupancy never exceeds `K`.
- R4: A push while full leaves the contents unchanged and raises `err_o` for the following cycle.
- R5: A pop while empty leaves the queue unchanged and raises `err_o` for the following cycle.
- R6: A combine with two or more words held removes the two oldest words, a and b. It appends (a+b) mod 16 at the back, all in one clock, so the occupancy drops by one.
- R7: A combine with zero or one word held changes nothing and raises no error.
- R8: Commands are ranked combine, then pop, then push. When a higher-ranked command is asserted, lower-ranked commands in the same cycle are ignored and cannot raise an error.
- R9: A combine on a full queue is legal. Its result lands in the slot freed by the oldest word, and the queue then holds `K`-1 words.
- R10: `err_o` is high for exactly one cycle per illegal command. It is low after any legal or ignored command.
- R11: `head_o` shows the oldest word when the queue is not empty, and 0 when it is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_i | input | 1 | Push `din_i` at the back |
| deq_i | input | 1 | Pop the front word |
| proc_i | input | 1 | Combine the two oldest words into their sum |
| din_i | input | W | Word to push |
| head_o | output | W | Oldest word, or 0 when empty |
| full_o | output | 1 | `K` words held |
| empty_o | output | 1 | No word held |
| err_o | output | 1 | One-cycle pulse after an illegal push or pop |

## Verification
The bench targets five corner cases:

- **Index wrap.** It runs pushes and pops across the wrap point. A design that mishandles the index carry returns words out of order there.
- **Full ring.** It combines on a completely full ring. A design that writes the sum before reading both operands corrupts the front word.
- **Combine below two words.** It combines with exactly zero and one word held. A design with an off-by-one occupancy test would pop from an empty slot.
- **Sum overflow.** It sums values above 15. A carry that leaks shows up as a wrong front value.
- **Overlapping commands.** It asserts several commands in one cycle. A design with the wrong ranking would push or raise an error where none is due.

A long pseudo-random sweep then compares every cycle against an arithmetic model of the queue.

// File: rtl/circq_sum.sv
module circq_sum #(
  parameter int K = 8,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enq_i,
  input  logic         deq_i,
  input  logic         proc_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         err_o
);
  localparam int AW = $clog2(K);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [K];
  logic [AW-1:0] head, tail, head_nx;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rd_a, rd_b;
  logic          do_proc, do_deq, do_enq, bad;
  logic          we;
  logic [W-1:0]  wd;

  assign head_nx = head + AW'(1);
  assign rd_a    = mem[head];
  assign rd_b    = mem[head_nx];

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(K));
  assign head_o  = empty_o ? '0 : rd_a;

  assign do_proc = proc_i && (cnt >= CW'(2));
  assign do_deq  = !proc_i && deq_i && !empty_o;
  assign do_enq  = !proc_i && !deq_i && enq_i && !full_o;
  assign bad     = !proc_i && ((deq_i && empty_o) || (!deq_i && enq_i && full_o));

  assign we = do_proc || do_enq;
  assign wd = do_proc ? W'(rd_a + rd_b) : din_i;

  always_ff @(posedge clk)
    if (we) mem[tail] <= wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      cnt   <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= bad;
      if (do_proc) begin
        head <= head + AW'(2);
        tail <= tail + AW'(1);
        cnt  <= cnt - CW'(1);
      end else if (do_deq) begin
        head <= head_nx;
        cnt  <= cnt - CW'(1);
      end else if (do_enq) begin
        tail <= tail + AW'(1);
        cnt  <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/circq_sum_chk.sv
module circq_sum_chk #(
  parameter int K = 8,
  parameter int W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enq_i,
  input logic                   deq_i,
  input logic                   proc_i,
  input logic [W-1:0]           din_i,
  input logic [W-1:0]           head_o,
  input logic                   full_o,
  input logic                   empty_o,
  input logic                   err_o,
  input logic [$clog2(K):0]     cnt
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o)); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(K)+1)'(K)); // R3
  AST_FIRST_PUSH_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    enq_i && empty_o && !deq_i && !proc_i |=> head_o == $past(din_i)); // R2
  AST_PUSH_FULL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    enq_i && full_o && !deq_i && !proc_i |=> err_o && full_o); // R4
  AST_POP_EMPTY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    deq_i && empty_o && !proc_i |=> err_o && empty_o); // R5
  AST_PROC_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    proc_i && empty_o |=> empty_o && !err_o); // R7
  AST_PROC_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    proc_i && full_o |=> !full_o && !empty_o && !err_o); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(!proc_i && (enq_i || deq_i))); // R10
  AST_EMPTY_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> head_o == '0); // R11
endmodule

bind circq_sum circq_sum_chk #(.K(K), .W(W)) u_chk (.*);

// File: tb/circq_sum_tb.sv
module circq_sum_tb;
  localparam int K = 8;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enq_i = 1'b0, deq_i = 1'b0, proc_i = 1'b0;
  logic [W-1:0] din_i = '0;
  logic [W-1:0] head_o;
  logic         full_o, empty_o, err_o;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] mq[$];

  always #2.5 clk = ~clk;

  circq_sum #(.K(K), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enq_i(enq_i), .deq_i(deq_i), .proc_i(proc_i),
    .din_i(din_i), .head_o(head_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic op(input logic e, input logic d, input logic p, input logic [W-1:0] v,
                    input string tag);
    logic xerr;
    logic [W-1:0] a, b;
    xerr = 1'b0;
    if (p) begin
      if (mq.size() >= 2) begin
        a = mq.pop_front(); b = mq.pop_front();
        mq.push_back(W'(a + b));
      end
    end else if (d) begin
      if (mq.size() == 0) xerr = 1'b1; else void'(mq.pop_front());
    end else if (e) begin
      if (mq.size() == K) xerr = 1'b1; else mq.push_back(v);
    end
    enq_i = e; deq_i = d; proc_i = p; din_i = v;
    @(posedge clk);
    @(negedge clk);
    enq_i = 1'b0; deq_i = 1'b0; proc_i = 1'b0;
    chk(tag, int'(err_o), int'(xerr), "err_o");
    chk(tag, int'(empty_o), int'(mq.size() == 0), "empty_o");
    chk(tag, int'(full_o), int'(mq.size() == K), "full_o");
    chk(tag, int'(head_o), mq.size() ? int'(mq[0]) : 0, "head_o");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R1", int'(empty_o), 1, "empty in reset");
    chk("R1", int'(full_o), 0, "full in reset");
    chk("R1", int'(err_o), 0, "err in reset");
    chk("R1", int'(head_o), 0, "head in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(empty_o), 1, "empty after reset");
    chk("R11", int'(head_o), 0, "head when empty");

    // R5: pop while empty, twice back to back, then R10 pulse ends
    op(0, 1, 0, 0, "R5");
    op(0, 1, 0, 0, "R5");
    op(0, 0, 0, 0, "R10");
    // R7: combine on empty and on one word
    op(0, 0, 1, 0, "R7");
    op(1, 0, 0, 4'd9, "R2");
    op(0, 0, 1, 0, "R7");
    op(0, 1, 0, 0, "R2");
    // R2/R3/R4: fill, overflow, drain in order
    for (int i = 0; i < K; i++) op(1, 0, 0, W'(i * 3 + 1), "R3");
    op(1, 0, 0, 4'hF, "R4");
    op(1, 0, 0, 4'hE, "R4");
    op(0, 0, 0, 0, "R10");
    // R9: combine on full ring
    op(0, 0, 1, 0, "R9");
    op(1, 0, 0, 4'h2, "R3");
    for (int i = 0; i < K; i++) op(0, 1, 0, 0, "R2");
    // wrap region
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 5; i++) op(1, 0, 0, W'(r * 5 + i), "R2");
      for (int i = 0; i < 4; i++) op(0, 1, 0, 0, "R2");
    end
    while (mq.size() != 0) op(0, 1, 0, 0, "R2");
    // R6: 1..5 reduces to 15
    for (int i = 1; i <= 5; i++) op(1, 0, 0, W'(i), "R6");
    for (int i = 0; i < 4; i++) op(0, 0, 1, 0, "R6");
    chk("R6", int'(head_o), 15, "sum of 1..5");
    op(0, 0, 1, 0, "R7");
    // R9: modulo-16 sum
    op(1, 0, 0, 4'hC, "R9");
    op(0, 0, 1, 0, "R9");
    chk("R9", int'(head_o), 11, "15+12 mod 16");
    // R8: ranking
    op(1, 0, 0, 4'h7, "R8");
    op(1, 0, 1, 4'h3, "R8");
    op(1, 1, 0, 4'h5, "R8");
    op(0, 1, 1, 0, "R8");
    op(1, 1, 1, 4'h1, "R8");
    while (mq.size() != 0) op(0, 1, 0, 0, "R2");
    op(1, 1, 0, 4'h6, "R8");
    // near-exhaustive sweep of command mixes
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2: op(1, 0, 0, lfsr[7:4], "R2");
        3'd3, 3'd4:       op(0, 1, 0, 0, "R2");
        3'd5:             op(0, 0, 1, 0, "R6");
        default:          op(lfsr[8], lfsr[9], lfsr[10], lfsr[14:11], "R8");
      endcase
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule